// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Engine

This block takes received Ethernet frames from a byte stream and stores them in memory buffers that software provides. Buffers are described by a ring of two-word descriptors. The first word holds status and length, and the word at offset 4 holds the buffer byte address. The engine fetches a descriptor and uses it only if software has set the ownership flag. It packs the incoming bytes into 32-bit little-endian words and writes each word into the buffer. When the buffer fills or the frame ends, it writes the status word back: ownership cleared, length, start and end markers, the wrap flag software set, and the error flags. A frame longer than one buffer is chained across consecutive descriptors.

When the engine meets a descriptor that software has not armed, it enters a starved state and raises `no_desc`. In that state it keeps taking bytes from the stream and discards them. It polls the descriptor again at a fixed interval, but only between frames. The next descriptor it retires then carries the overflow flag. A one-cycle interrupt pulse follows every end-of-packet write-back. One process holds the state register and one produces the outputs.

The states are:
- **FETCH**: reads the status word.
- **CHECK**: tests ownership. It goes to ADDR if the descriptor is owned and to STARVE if not.
- **ADDR**: latches the buffer address, then goes to FILL.
- **FILL**: accepts bytes. It goes to STORE when a word is complete, the frame ends, or the buffer is full.
- **STORE**: writes one data word. It returns to FILL, or goes to RETIRE when the frame has ended or the buffer is full.
- **RETIRE**: writes the status word back, then goes to FETCH.
- **STARVE**: discards bytes. It goes to FETCH when the poll interval has expired and no frame is open.

Top module: `rx_ring_dma`

## Requirements
- R1: Reset state. While reset is held, `in_ready`, `irq` and `no_desc` are 0, and the engine presents a read of the status word at `ring_base`.
- R2: Descriptor layout and ownership.
  - Descriptor n sits at `ring_base + 8*n`, with the buffer address at offset 4.
  - In the status word, the length field is bits 27:16, ownership is bit 15, end-of-packet is bit 14, start-of-packet is bit 13 and wrap is bit 12.
  - Only descriptors with bit 15 set are used. Write-back clears bit 15 and keeps bit 12 as read.
- R3: Data packing. Byte k of a buffer goes to the word at buffer address + 4*(k/4), lane k%4, with lane 0 in bits 7:0. Every data write is a single word. Unused lanes of a frame's last word are 0.
- R4: Chaining.
  - A frame longer than `BUF_BYTES` spans consecutive descriptors.
  - Bit 13 is set only on the first descriptor of a frame and bit 14 only on the last.
  - Non-final descriptors carry length `BUF_BYTES`. The final descriptor carries the total frame length.
- R5: Ring advance. After a descriptor whose bit 12 was set, the next fetch is at `ring_base`. Otherwise the next fetch is 8 bytes further on.
- R6: Oversize. A frame longer than `MAX_FRAME` bytes (default 2046) sets bit 4 in its final descriptor.
- R7: Frame errors. An `in_err` strobe on any byte sets bit 2, and `in_crc_bad` on the last byte sets bit 1. Both flags, and the oversize flag, appear only on the final descriptor of the frame.
- R8: Starvation.
  - On an unowned descriptor, `no_desc` rises, `in_ready` stays 1, and incoming bytes are discarded with no memory write.
  - The descriptor is re-read every `POLL_CYCLES` cycles, but only when no frame is open.
- R9: Overflow. After bytes have been dropped, the next descriptor written back has bit 0 set. Later descriptors do not.
- R10: Interrupt. `irq` is a one-cycle pulse, two cycles after the clock edge that accepts a frame's last byte. There is exactly one pulse per stored frame and none for a dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of descriptor 0 |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Receive symbol error on this byte |
| in_crc_bad | input | 1 | CRC failure, qualified by in_last |
| in_ready | output | 1 | Engine accepts the stream byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| no_desc | output | 1 | Engine is starved of descriptors |
| irq | output | 1 | End-of-packet interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle:
- an unowned read leads straight to the starved state;
- a wrapped write-back is followed by a fetch at the ring base;
- data writes stay inside the current buffer;
- error flags appear only on end-of-packet write-backs;
- every interrupt pulse follows such a write-back and lasts one cycle.

Other behaviour only the bench scenarios can show:
- the byte-exact buffer contents;
- the chained lengths and markers over a sweep of every frame length from 1 to past the oversize limit;
- the wrap walk through a four-descriptor ring;
- the dropped frame, and the single overflow mark that follows it.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_CHECK,
        ST_ADDR,
        ST_FILL,
        ST_STORE,
        ST_RETIRE,
        ST_STARVE
    } rx_state_e;

    // status word field positions (software decodes these)
    localparam int LEN_LSB  = 16;
    localparam int LEN_W    = 12;
    localparam int OWN_BIT  = 15;
    localparam int EOP_BIT  = 14;
    localparam int SOP_BIT  = 13;
    localparam int WRAP_BIT = 12;
    localparam int OVSZ_BIT = 4;
    localparam int SYM_BIT  = 2;
    localparam int CRC_BIT  = 1;
    localparam int OVF_BIT  = 0;

    localparam int DESC_BYTES = 8;

endpackage

// File: rtl/rx_word_packer.sv
module rx_word_packer #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                take,
    input  logic [7:0]          byte_in,
    output logic [WORD_W-1:0]   word,
    output logic [$clog2(WORD_W/8):0] lanes
);
    localparam int LANES  = WORD_W / 8;
    localparam int LSEL_W = $clog2(LANES);

    logic [LSEL_W-1:0] sel;
    assign sel = lanes[LSEL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            lanes <= '0;
        end else if (flush) begin
            word  <= '0;
            lanes <= '0;
        end else if (take) begin
            word[{sel, 3'b000} +: 8] <= byte_in;
            lanes <= lanes + 1'b1;
        end
    end

    // R3: a word never takes more bytes than it has lanes
    p_lane_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes == ($clog2(WORD_W/8)+1)'(LANES)) |-> !take);

endmodule

// File: rtl/rx_frame_meter.sv
module rx_frame_meter #(
    parameter int CNT_W     = 16,
    parameter int MAX_FRAME = 2046
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             last,
    input  logic             sym_err,
    input  logic             crc_bad,
    output logic [CNT_W-1:0] total,
    output logic             frame_open,
    output logic             sym_seen,
    output logic             crc_seen,
    output logic             oversize
);
    logic starting;
    assign starting = take && !frame_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total      <= '0;
            frame_open <= 1'b0;
            sym_seen   <= 1'b0;
            crc_seen   <= 1'b0;
        end else if (take) begin
            frame_open <= !last;
            if (starting) begin
                total    <= CNT_W'(1);
                sym_seen <= sym_err;
                crc_seen <= last && crc_bad;
            end else begin
                if (total != '1) total <= total + 1'b1;
                sym_seen <= sym_seen | sym_err;
                crc_seen <= crc_seen | (last && crc_bad);
            end
        end
    end

    assign oversize = (total > CNT_W'(MAX_FRAME));

    // R6: the count only ever restarts at one on a new frame
    p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !frame_open) |=> (total == CNT_W'(1)));

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rx_ring_pkg::*;
#(
    parameter int BUF_BYTES   = 2048,
    parameter int MAX_FRAME   = 2046,
    parameter int POLL_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ring_base,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_err,
    input  logic        in_crc_bad,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        no_desc,
    output logic        irq
);
    localparam int BC_W    = $clog2(BUF_BYTES + 1);
    localparam int PW      = $clog2(POLL_CYCLES + 1);
    localparam int CNT_W   = 16;
    localparam int LANE_W  = 3;
    localparam int LEN_MAX = (1 << LEN_W) - 1;

    rx_state_e state, state_nx;

    logic [31:0]      desc_off;
    logic [31:0]      buf_addr;
    logic [BC_W-1:0]  buf_cnt;
    logic [BC_W-1:0]  wr_off;
    logic [PW-1:0]    poll_cnt;
    logic             wrap_q, first_q, ended_q, ovf_pend, irq_q;

    logic [31:0]      pk_word;
    logic [LANE_W-1:0] pk_lanes;
    logic [CNT_W-1:0] fr_total;
    logic             fr_open, fr_sym, fr_crc, fr_ovsz;

    logic             take;
    logic             fill_take;
    logic             close_word;
    logic             buf_full;
    logic             poll_done;
    logic [LEN_W-1:0] len_field;
    logic [31:0]      wb_word;

    assign take      = in_valid && in_ready;
    assign fill_take = take && (state == ST_FILL);
    assign buf_full  = (buf_cnt == BC_W'(BUF_BYTES));
    assign close_word = (pk_lanes == LANE_W'(3)) || in_last ||
                        (buf_cnt == BC_W'(BUF_BYTES - 1));
    assign poll_done = (poll_cnt == PW'(POLL_CYCLES - 1));

    rx_word_packer #(.WORD_W(32)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (state == ST_STORE),
        .take    (fill_take),
        .byte_in (in_data),
        .word    (pk_word),
        .lanes   (pk_lanes)
    );

    rx_frame_meter #(.CNT_W(CNT_W), .MAX_FRAME(MAX_FRAME)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .last       (in_last),
        .sym_err    (in_err),
        .crc_bad    (in_crc_bad),
        .total      (fr_total),
        .frame_open (fr_open),
        .sym_seen   (fr_sym),
        .crc_seen   (fr_crc),
        .oversize   (fr_ovsz)
    );

    always_comb begin
        if (!ended_q)
            len_field = LEN_W'(BUF_BYTES);
        else if (fr_total > CNT_W'(LEN_MAX))
            len_field = LEN_W'(LEN_MAX);
        else
            len_field = fr_total[LEN_W-1:0];
        wb_word = '0;
        wb_word[LEN_LSB +: LEN_W] = len_field;
        wb_word[EOP_BIT]  = ended_q;
        wb_word[SOP_BIT]  = first_q;
        wb_word[WRAP_BIT] = wrap_q;
        wb_word[OVSZ_BIT] = ended_q && fr_ovsz;
        wb_word[SYM_BIT]  = ended_q && fr_sym;
        wb_word[CRC_BIT]  = ended_q && fr_crc;
        wb_word[OVF_BIT]  = ovf_pend;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_CHECK;
            ST_CHECK:  state_nx = mem_rdata[OWN_BIT] ? ST_ADDR : ST_STARVE;
            ST_ADDR:   state_nx = ST_FILL;
            ST_FILL:   if (fill_take && close_word) state_nx = ST_STORE;
            ST_STORE:  state_nx = (ended_q || buf_full) ? ST_RETIRE : ST_FILL;
            ST_RETIRE: state_nx = ST_FETCH;
            ST_STARVE: if (poll_done && !fr_open && !in_valid) state_nx = ST_FETCH;
            default:   state_nx = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ring_base + desc_off;
        mem_wdata = '0;
        in_ready  = 1'b0;
        no_desc   = 1'b0;
        unique case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_CHECK: if (mem_rdata[OWN_BIT]) begin
                mem_req  = 1'b1;
                mem_addr = ring_base + desc_off + 32'd4;
            end
            ST_ADDR: ;
            ST_FILL: in_ready = 1'b1;
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr + 32'(wr_off);
                mem_wdata = pk_word;
            end
            ST_RETIRE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb_word;
            end
            ST_STARVE: begin
                in_ready = 1'b1;
                no_desc  = 1'b1;
            end
            default: ;
        endcase
    end

    assign irq = irq_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_off <= '0;
            buf_addr <= '0;
            buf_cnt  <= '0;
            wr_off   <= '0;
            poll_cnt <= '0;
            wrap_q   <= 1'b0;
            first_q  <= 1'b1;
            ended_q  <= 1'b0;
            ovf_pend <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                ST_CHECK: begin
                    wrap_q   <= mem_rdata[WRAP_BIT];
                    poll_cnt <= '0;
                end
                ST_ADDR: buf_addr <= mem_rdata;
                ST_FILL: if (fill_take) begin
                    buf_cnt <= buf_cnt + 1'b1;
                    if (in_last) ended_q <= 1'b1;
                end
                ST_STORE: wr_off <= wr_off + BC_W'(4);
                ST_RETIRE: begin
                    irq_q    <= ended_q;
                    first_q  <= ended_q;
                    ended_q  <= 1'b0;
                    ovf_pend <= 1'b0;
                    buf_cnt  <= '0;
                    wr_off   <= '0;
                    desc_off <= wrap_q ? 32'd0 : desc_off + 32'(DESC_BYTES);
                end
                ST_STARVE: begin
                    if (!poll_done) poll_cnt <= poll_cnt + 1'b1;
                    if (take) begin
                        ovf_pend <= 1'b1;
                        first_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: an unowned descriptor sends the engine straight to starvation
    p_starve_on_unowned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !mem_rdata[OWN_BIT]) |=> no_desc);

    // R5: a retired wrap descriptor is followed by a fetch at the ring base
    p_wrap_to_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETIRE && wrap_q) |=> (mem_req && !mem_we && mem_addr == ring_base));

    // R3: data writes never leave the current buffer
    p_write_in_buffer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == ST_STORE) |-> ((mem_addr - buf_addr) < 32'(BUF_BYTES)));

    // R7: error flags appear only together with end of packet
    p_flags_on_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETIRE && !mem_wdata[EOP_BIT]) |-> (mem_wdata[4:1] == 4'b0000));

    // R10: interrupt follows an end-of-packet write-back and lasts one cycle
    p_irq_after_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(state == ST_RETIRE && mem_wdata[EOP_BIT]));
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: no data written while starved
    p_no_write_starved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_desc |-> !mem_we);

endmodule

// File: tb/tb_rx_ring_dma.sv
module tb_rx_ring_dma;
    localparam int BUFB   = 16;
    localparam int MAXF   = 40;
    localparam int POLL   = 8;
    localparam int NDESC  = 4;
    localparam int BUFBASE = 32'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] ring_base = 32'h0;
    logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0, in_crc_bad = 1'b0;
    logic [7:0] in_data = 8'h0;
    logic in_ready, mem_req, mem_we, no_desc, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    rx_ring_dma #(.BUF_BYTES(BUFB), .MAX_FRAME(MAXF), .POLL_CYCLES(POLL)) dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_err(in_err), .in_crc_bad(in_crc_bad), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .no_desc(no_desc), .irq(irq)
    );

    // memory model with one-cycle read latency and a host write path
    logic [31:0] mem [0:255];
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = 32'h0, hw_data = 32'h0;
    int dut_wr_cnt = 0;
    int irq_cnt = 0;

    always @(posedge clk) begin
        if (hw_en) mem[hw_addr[9:2]] <= hw_data;
        if (mem_req && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            dut_wr_cnt = dut_wr_cnt + 1;
        end
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        if (irq) irq_cnt = irq_cnt + 1;
    end

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    function automatic logic [31:0] arm_word(input int d);
        return 32'h8000 | ((d == NDESC - 1) ? 32'h1000 : 32'h0);
    endfunction

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 13 + i * 7 + 1) & 255);
    endfunction

    task automatic send_frame(input int len, input int sym_pos, input bit crc);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(len, i);
            in_last = (i == len - 1); in_err = (i == sym_pos);
            in_crc_bad = crc && (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; in_crc_bad = 1'b0;
    endtask

    int nxt = 0;

    // store a frame and check all of it; returns after re-arming
    task automatic run_frame(input int len, input int sym_pos, input bit crc, input bit ovf_exp);
        int nb, lat, irq0;
        bit data_ok;
        irq0 = irq_cnt;
        send_frame(len, sym_pos, crc);
        lat = 0;
        while (!irq && lat < 50) begin @(negedge clk); lat++; end
        check(lat == 2, "R10", "irq latency", 32'(lat), 32'd2);
        @(negedge clk);
        check(!irq && irq_cnt == irq0 + 1, "R10", "irq single pulse", 32'(irq_cnt - irq0), 32'd1);
        nb = (len + BUFB - 1) / BUFB;
        data_ok = 1'b1;
        for (int p = 0; p < nb; p++) begin
            int d, plen;
            logic [31:0] exp_st;
            d = (nxt + p) % NDESC;
            plen = (p == nb - 1) ? len - p * BUFB : BUFB;
            exp_st = 32'(((p == nb - 1) ? len : BUFB)) << 16;
            if (p == nb - 1) exp_st |= 32'h4000;
            if (p == 0) exp_st |= 32'h2000;
            if (d == NDESC - 1) exp_st |= 32'h1000;
            if (p == nb - 1 && len > MAXF) exp_st |= 32'h10;
            if (p == nb - 1 && sym_pos >= 0) exp_st |= 32'h4;
            if (p == nb - 1 && crc) exp_st |= 32'h2;
            if (p == 0 && ovf_exp) exp_st |= 32'h1;
            check(mem[2 * d] == exp_st, "R2 R4 R5 R6 R7 R9", $sformatf("status desc %0d len %0d", d, len),
                  mem[2 * d], exp_st);
            for (int w = 0; w < (plen + 3) / 4; w++) begin
                for (int l = 0; l < 4; l++) begin
                    int k;
                    logic [7:0] eb, ab;
                    k = w * 4 + l;
                    eb = (k < plen) ? pat(len, p * BUFB + k) : 8'h00;
                    ab = mem[(BUFBASE >> 2) + d * 16 + w][l*8 +: 8];
                    if (ab != eb) data_ok = 1'b0;
                end
            end
        end
        check(data_ok, "R3", $sformatf("buffer bytes len %0d", len), 32'(data_ok), 32'd1);
        for (int p = 0; p < nb; p++) host_write(32'(8 * ((nxt + p) % NDESC)), arm_word((nxt + p) % NDESC));
        nxt = (nxt + nb) % NDESC;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int k, wc, ic, wt;
        for (int d = 0; d < NDESC; d++) begin
            host_write(32'(8 * d), arm_word(d));
            host_write(32'(8 * d + 4), 32'(BUFBASE + 64 * d));
        end
        @(negedge clk);
        check(!in_ready && !irq && !no_desc && mem_req && !mem_we && mem_addr == ring_base,
              "R1", "reset outputs", {in_ready, irq, no_desc, mem_req, mem_we}, 32'h2);
        rst_n = 1'b1;

        // sweep every frame length through the oversize limit
        for (int len = 1; len <= MAXF + 4; len++)
            run_frame(len, (len % 5 == 0) ? len / 2 : -1, (len % 7 == 3), 1'b0);

        // starvation: keep only the current descriptor armed
        k = nxt;
        for (int d = 0; d < NDESC; d++)
            if (d != k) host_write(32'(8 * d), arm_word(d) & ~32'h8000);
        run_frame(5, -1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check(no_desc && in_ready, "R8", "starved outputs", {no_desc, in_ready}, 32'h3);
        wc = dut_wr_cnt; ic = irq_cnt;
        send_frame(6, -1, 1'b0);
        repeat (10) @(negedge clk);
        check(dut_wr_cnt == wc, "R8", "writes during drop", 32'(dut_wr_cnt - wc), 32'd0);
        check(irq_cnt == ic, "R10", "no irq for dropped frame", 32'(irq_cnt - ic), 32'd0);
        check(mem[2 * nxt] == (arm_word(nxt) & ~32'h8000), "R8", "unowned desc untouched",
              mem[2 * nxt], arm_word(nxt) & ~32'h8000);
        for (int d = 0; d < NDESC; d++) host_write(32'(8 * d), arm_word(d));
        wt = 0;
        while (no_desc && wt < POLL + 20) begin @(negedge clk); wt++; end
        check(!no_desc, "R8", "poll recovers", 32'(no_desc), 32'd0);
        run_frame(7, -1, 1'b0, 1'b1);   // R9: overflow mark on next descriptor
        run_frame(3, -1, 1'b0, 1'b0);   // R9: mark not repeated

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule